// File: doc/BRIEF.md
# Banked SPI Register Front End

This block sits between a simple 32-bit read/write bus and four SPI channel engines. Every channel owns an identical register bank placed at channel index times 0x40. The bank holds a word for configuration, a clock divider, a command word, a status word that software clears by writing ones, an interrupt enable mask, FIFO thresholds, a read-only FIFO level word, and two data ports. One system-control word at 0x100 holds one reset bit per channel and a power-management enable bit.

The engines, shift registers and FIFO storage are outside the block. The block takes event pulses, a busy flag and FIFO levels from each engine, and keeps the per-channel status sticky until software clears it. It drives the stored configuration, divider and command words back to the engine. A write to a data port becomes a push strobe. A read of a receive port returns the engine's head word and gives a pop strobe. All enabled status bits of all channels are merged into one interrupt line.

Top module: `spi_bank_regs`

## Requirements
- R1: The bank of channel n starts at n*0x40. Within a bank, the word offsets are 0x00 configuration (32 bits), 0x04 divider (low 16 bits stored), 0x08 command (32 bits), 0x0C status, 0x10 interrupt enable (low 5 bits), 0x14 threshold (low 8 bits), 0x18 FIFO levels, 0x1C transmit data and 0x20 receive data. A write to one bank leaves every other bank unchanged. The stored configuration, divider and command values are driven on cfg_o, div_o and cmd_o in slice n.
- R2: Status bit 0 reads as the live busy_i flag of the channel. A status read returns zeros above bit 5.
- R3: A one-cycle pulse is recorded in status and held until cleared: ev_done_i sets bit 1, ev_txuf_i sets bit 4 and ev_rxof_i sets bit 5.
- R4: A write to the status word clears each of bits 1 to 5 whose write-data bit is 1. A status bit written with 0 keeps its value, and bit 0 is unaffected.
- R5: When a status bit is set and cleared in the same cycle, the set wins.
- R6: The threshold word holds the transmit threshold in bits [7:4] and the receive threshold in bits [3:0], and resets to 0x24. Status bit 2 is set while the transmit level is at or below its threshold. Status bit 3 is set while the receive level is at or above its threshold.
- R7: The FIFO level word reads the transmit level in bits [7:4] and the receive level in bits [3:0].
- R8: irq_o is the OR over all channels of each status bit 1 to 5 ANDed with enable bit 0 to 4 respectively. Status bit 0 never raises irq_o.
- R9: The word at 0x100 keeps bits [3:0] as per-channel reset controls (chan_rst_o) and bit 8 as pm_en_o. All of its other bits read 0.
- R10: While a channel's reset bit is set, its status reads 0 and ignores events, its command word is 0, and a command write neither stores a value nor pulses cmd_wr_o. A command write to a channel not in reset pulses cmd_wr_o for that channel in the write cycle.
- R11: A write to a transmit data port pulses tx_push_o for that channel only, with the written word on tx_data_o. A read of a receive data port returns that channel's rx_data_i slice and pulses rx_pop_o for that channel only.
- R12: A read of an address outside the nine bank words and the system-control word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| bus_addr_i | input | 9 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| busy_i | input | 4 | Per-channel transfer in progress |
| ev_done_i | input | 4 | Per-channel transfer-complete pulse |
| ev_txuf_i | input | 4 | Per-channel transmit underflow pulse |
| ev_rxof_i | input | 4 | Per-channel receive overflow pulse |
| tx_lvl_i | input | 16 | Transmit FIFO level, 4 bits per channel |
| rx_lvl_i | input | 16 | Receive FIFO level, 4 bits per channel |
| rx_data_i | input | 128 | Receive FIFO head word, 32 bits per channel |
| cfg_o | output | 128 | Configuration words |
| div_o | output | 64 | Divider values, 16 bits per channel |
| cmd_o | output | 128 | Command words |
| cmd_wr_o | output | 4 | Command written strobe |
| tx_push_o | output | 4 | Transmit FIFO push strobe |
| tx_data_o | output | 32 | Word to push |
| rx_pop_o | output | 4 | Receive FIFO pop strobe |
| chan_rst_o | output | 4 | Per-channel reset |
| pm_en_o | output | 1 | Power-management enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The status and interrupt path is driven from a table of cases. Each case sets a channel, a threshold, FIFO levels, a set of event pulses and an enable mask. The cases cover each source alone, threshold comparisons exactly at their limits and one step past them, levels that match both thresholds at once, and all events together with the mask cleared. Together they tell apart a wrong status bit position, a wrong enable-to-status mapping, an off-by-one threshold compare and a leak into the wrong bank. Directed cases cover partial and simultaneous clears, the pending bit kept out of the interrupt, several channels ORed together, channel reset, the data-port strobes and unmapped addresses.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;
  // word index inside a bank (address bits [5:2])
  localparam logic [3:0] RI_CFG  = 4'd0;
  localparam logic [3:0] RI_DIV  = 4'd1;
  localparam logic [3:0] RI_CMD  = 4'd2;
  localparam logic [3:0] RI_STAT = 4'd3;
  localparam logic [3:0] RI_IEN  = 4'd4;
  localparam logic [3:0] RI_THR  = 4'd5;
  localparam logic [3:0] RI_WCNT = 4'd6;
  localparam logic [3:0] RI_TXD  = 4'd7;
  localparam logic [3:0] RI_RXD  = 4'd8;

  localparam int unsigned BANK_SHIFT = 6;
  localparam int unsigned SYS_OFF    = 'h100;
  localparam int unsigned PM_BIT     = 8;
  localparam int unsigned STAT_W     = 6;
  localparam int unsigned IEN_W      = 5;
endpackage

// File: rtl/spi_addr_dec.sv
module spi_addr_dec
  import spi_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bank_hit_o,
  output logic [CH_W-1:0]   bank_sel_o,
  output logic [3:0]        idx_o,
  output logic              sys_hit_o
);
  localparam int unsigned BN_W = ADDR_W - BANK_SHIFT;
  localparam logic [BN_W-1:0] NCH_L = BN_W'(NUM_CH);

  logic [BN_W-1:0] bank_num;

  assign bank_num   = addr_i[ADDR_W-1:BANK_SHIFT];
  assign idx_o      = addr_i[5:2];
  assign bank_sel_o = bank_num[CH_W-1:0];
  assign bank_hit_o = (addr_i[1:0] == 2'b00) && (bank_num < NCH_L) && (addr_i[5:2] <= RI_RXD);
  assign sys_hit_o  = (addr_i == ADDR_W'(SYS_OFF));
endmodule

// File: rtl/spi_stat_w1c.sv
module spi_stat_w1c
  import spi_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_clr_i,
  input  logic              busy_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:1] clr_mask_i,
  input  logic [STAT_W-1:1] set_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:1] sticky_q;
  logic [STAT_W-1:1] clr;

  assign clr = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sticky_q <= '0;
    else if (hold_clr_i) sticky_q <= '0;
    else                 sticky_q <= (sticky_q & ~clr) | set_i; // set wins
  end

  assign stat_o = {sticky_q, busy_i & ~hold_clr_i};
endmodule

// File: rtl/spi_chan_regs.sv
module spi_chan_regs
  import spi_bank_pkg::*;
#(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned DIV_W = 16,
  parameter logic [2*LVL_W-1:0] THR_RST = 8'h24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_rst_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [3:0]        idx_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              ev_done_i,
  input  logic              ev_txuf_i,
  input  logic              ev_rxof_i,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  input  logic [LVL_W-1:0]  rx_lvl_i,
  input  logic [31:0]       rx_data_i,
  output logic [31:0]       rdata_o,
  output logic [31:0]       cfg_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [31:0]       cmd_o,
  output logic              cmd_wr_o,
  output logic              tx_push_o,
  output logic              rx_pop_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [31:0]        cfg_q, cmd_q;
  logic [DIV_W-1:0]   div_q;
  logic [IEN_W-1:0]   ien_q;
  logic [2*LVL_W-1:0] thr_q;
  logic               tx_thr_hit, rx_thr_hit;
  logic [STAT_W-1:1]  set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      div_q <= '0;
      ien_q <= '0;
      thr_q <= THR_RST;
    end else if (wr_i) begin
      case (idx_i)
        RI_CFG:  cfg_q <= wdata_i;
        RI_DIV:  div_q <= wdata_i[DIV_W-1:0];
        RI_IEN:  ien_q <= wdata_i[IEN_W-1:0];
        RI_THR:  thr_q <= wdata_i[2*LVL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cmd_q <= '0;
    else if (chan_rst_i)                      cmd_q <= '0;
    else if (wr_i && (idx_i == RI_CMD))       cmd_q <= wdata_i;
  end

  assign cmd_wr_o  = wr_i && (idx_i == RI_CMD) && !chan_rst_i;
  assign tx_push_o = wr_i && (idx_i == RI_TXD);
  assign rx_pop_o  = rd_i && (idx_i == RI_RXD);

  assign tx_thr_hit = (tx_lvl_i <= thr_q[2*LVL_W-1:LVL_W]);
  assign rx_thr_hit = (rx_lvl_i >= thr_q[LVL_W-1:0]);
  assign set_vec    = {ev_rxof_i, ev_txuf_i, rx_thr_hit, tx_thr_hit, ev_done_i};

  spi_stat_w1c u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_clr_i (chan_rst_i),
    .busy_i     (busy_i),
    .clr_we_i   (wr_i && (idx_i == RI_STAT)),
    .clr_mask_i (wdata_i[STAT_W-1:1]),
    .set_i      (set_vec & {(STAT_W-1){~chan_rst_i}}),
    .stat_o     (stat_o)
  );

  // enable bit k gates status bit k+1
  assign irq_o = |(stat_o[STAT_W-1:1] & ien_q);

  always_comb begin
    case (idx_i)
      RI_CFG:  rdata_o = cfg_q;
      RI_DIV:  rdata_o = 32'(div_q);
      RI_CMD:  rdata_o = cmd_q;
      RI_STAT: rdata_o = 32'(stat_o);
      RI_IEN:  rdata_o = 32'(ien_q);
      RI_THR:  rdata_o = 32'(thr_q);
      RI_WCNT: rdata_o = 32'({tx_lvl_i, rx_lvl_i});
      RI_RXD:  rdata_o = rx_data_i;
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
  assign div_o = div_q;
  assign cmd_o = cmd_q;
endmodule

// File: rtl/spi_bank_regs.sv
module spi_bank_regs
  import spi_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned DIV_W  = 16,
  parameter logic [2*LVL_W-1:0] THR_RST = 8'h24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_we_i,
  input  logic                    bus_re_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [31:0]             bus_wdata_i,
  output logic [31:0]             bus_rdata_o,
  input  logic [NUM_CH-1:0]       busy_i,
  input  logic [NUM_CH-1:0]       ev_done_i,
  input  logic [NUM_CH-1:0]       ev_txuf_i,
  input  logic [NUM_CH-1:0]       ev_rxof_i,
  input  logic [NUM_CH*LVL_W-1:0] tx_lvl_i,
  input  logic [NUM_CH*LVL_W-1:0] rx_lvl_i,
  input  logic [NUM_CH*32-1:0]    rx_data_i,
  output logic [NUM_CH*32-1:0]    cfg_o,
  output logic [NUM_CH*DIV_W-1:0] div_o,
  output logic [NUM_CH*32-1:0]    cmd_o,
  output logic [NUM_CH-1:0]       cmd_wr_o,
  output logic [NUM_CH-1:0]       tx_push_o,
  output logic [31:0]             tx_data_o,
  output logic [NUM_CH-1:0]       rx_pop_o,
  output logic [NUM_CH-1:0]       chan_rst_o,
  output logic                    pm_en_o,
  output logic                    irq_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [31:0] SYS_MASK = (32'd1 << PM_BIT) | ((32'd1 << NUM_CH) - 32'd1);

  logic              bank_hit, sys_hit;
  logic [CH_W-1:0]   bank_sel;
  logic [3:0]        idx;
  logic [31:0]       sys_q;
  logic [31:0]       chan_rdata [NUM_CH];
  logic [NUM_CH-1:0] chan_irq;
  logic [NUM_CH*STAT_W-1:0] stat_flat;

  spi_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i     (bus_addr_i),
    .bank_hit_o (bank_hit),
    .bank_sel_o (bank_sel),
    .idx_o      (idx),
    .sys_hit_o  (sys_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sys_q <= '0;
    else if (bus_we_i && sys_hit) sys_q <= bus_wdata_i & SYS_MASK;
  end

  assign chan_rst_o = sys_q[NUM_CH-1:0];
  assign pm_en_o    = sys_q[PM_BIT];
  assign tx_data_o  = bus_wdata_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = bank_hit && (bank_sel == CH_W'(g));

    spi_chan_regs #(.LVL_W(LVL_W), .DIV_W(DIV_W), .THR_RST(THR_RST)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .chan_rst_i (sys_q[g]),
      .wr_i       (bus_we_i && hit),
      .rd_i       (bus_re_i && hit),
      .idx_i      (idx),
      .wdata_i    (bus_wdata_i),
      .busy_i     (busy_i[g]),
      .ev_done_i  (ev_done_i[g]),
      .ev_txuf_i  (ev_txuf_i[g]),
      .ev_rxof_i  (ev_rxof_i[g]),
      .tx_lvl_i   (tx_lvl_i[g*LVL_W +: LVL_W]),
      .rx_lvl_i   (rx_lvl_i[g*LVL_W +: LVL_W]),
      .rx_data_i  (rx_data_i[g*32 +: 32]),
      .rdata_o    (chan_rdata[g]),
      .cfg_o      (cfg_o[g*32 +: 32]),
      .div_o      (div_o[g*DIV_W +: DIV_W]),
      .cmd_o      (cmd_o[g*32 +: 32]),
      .cmd_wr_o   (cmd_wr_o[g]),
      .tx_push_o  (tx_push_o[g]),
      .rx_pop_o   (rx_pop_o[g]),
      .stat_o     (stat_flat[g*STAT_W +: STAT_W]),
      .irq_o      (chan_irq[g])
    );
  end

  assign irq_o = |chan_irq;

  always_comb begin
    if (sys_hit)       bus_rdata_o = sys_q;
    else if (bank_hit) bus_rdata_o = chan_rdata[bank_sel];
    else               bus_rdata_o = '0;
  end
endmodule

// File: rtl/spi_bank_regs_chk.sv
module spi_bank_regs_chk
  import spi_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 9
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     bus_we_i,
  input logic [ADDR_W-1:0]        bus_addr_i,
  input logic                     w1c_bit4_i,
  input logic [NUM_CH-1:0]        ev_done_i,
  input logic [NUM_CH-1:0]        ev_txuf_i,
  input logic [NUM_CH-1:0]        chan_rst_o,
  input logic [NUM_CH-1:0]        cmd_wr_o,
  input logic [NUM_CH-1:0]        tx_push_o,
  input logic [NUM_CH-1:0]        rx_pop_o,
  input logic                     pm_en_o,
  input logic [NUM_CH*STAT_W-1:0] stat_i
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R3
    done_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_done_i[g] && !chan_rst_o[g]) |=> stat_i[g*STAT_W+1]);
    // R4
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == ADDR_W'(g*'h40 + 'h0C) && w1c_bit4_i && !ev_txuf_i[g])
      |=> !stat_i[g*STAT_W+4]);
    // R10
    rst_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chan_rst_o[g] |=> (stat_i[g*STAT_W+1 +: STAT_W-1] == '0));
    // R10
    rst_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chan_rst_o[g] |-> !stat_i[g*STAT_W]);
  end

  // R10
  no_cmd_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_rst_o & cmd_wr_o) == '0);
  // R11
  one_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(tx_push_o));
  // R11
  one_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(rx_pop_o));
  // R9
  pm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == ADDR_W'(SYS_OFF)) |=> $stable(pm_en_o));
endmodule

bind spi_bank_regs spi_bank_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .w1c_bit4_i (bus_wdata_i[4]),
  .ev_done_i  (ev_done_i),
  .ev_txuf_i  (ev_txuf_i),
  .chan_rst_o (chan_rst_o),
  .cmd_wr_o   (cmd_wr_o),
  .tx_push_o  (tx_push_o),
  .rx_pop_o   (rx_pop_o),
  .pm_en_o    (pm_en_o),
  .stat_i     (stat_flat)
);

// File: tb/tb_spi_bank_regs.sv
`timescale 1ns/1ps
module tb_spi_bank_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0, bus_re = 1'b0;
  logic [8:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  rdata;
  logic [3:0]   busy = '0, ev_done = '0, ev_txuf = '0, ev_rxof = '0;
  logic [15:0]  tx_lvl = {4{4'd8}}, rx_lvl = '0;
  logic [127:0] rx_data = '0;
  logic [127:0] cfg, cmd;
  logic [63:0]  div;
  logic [3:0]   cmd_wr, tx_push, rx_pop, chan_rst;
  logic [31:0]  tx_data;
  logic         pm_en, irq;

  always #4 clk = ~clk;

  spi_bank_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_re_i(bus_re),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
    .busy_i(busy), .ev_done_i(ev_done), .ev_txuf_i(ev_txuf), .ev_rxof_i(ev_rxof),
    .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl), .rx_data_i(rx_data),
    .cfg_o(cfg), .div_o(div), .cmd_o(cmd), .cmd_wr_o(cmd_wr),
    .tx_push_o(tx_push), .tx_data_o(tx_data), .rx_pop_o(rx_pop),
    .chan_rst_o(chan_rst), .pm_en_o(pm_en), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] ra(input int ch, input int off);
    return 9'(ch * 'h40 + off);
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    #2 chk(req, rdata, exp);
    @(negedge clk); bus_re = 1'b0;
  endtask

  // ev = {rxof, txuf, done}
  task automatic pulse(input int ch, input logic [2:0] ev);
    @(negedge clk); ev_done[ch] = ev[0]; ev_txuf[ch] = ev[1]; ev_rxof[ch] = ev[2];
    @(negedge clk); ev_done = '0; ev_txuf = '0; ev_rxof = '0;
  endtask

  typedef struct packed {
    logic [1:0] ch;
    logic [7:0] thr;
    logic [3:0] tx;
    logic [3:0] rx;
    logic [2:0] ev;
    logic [4:0] ien;
    logic [5:0] stat;
    logic       irq;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 8'h24, 4'd8, 4'd0, 3'b000, 5'h1F, 6'h00, 1'b0},
    '{2'd1, 8'h24, 4'd8, 4'd0, 3'b001, 5'h01, 6'h02, 1'b1},
    '{2'd2, 8'h24, 4'd1, 4'd0, 3'b000, 5'h02, 6'h04, 1'b1},
    '{2'd3, 8'h24, 4'd8, 4'd5, 3'b000, 5'h02, 6'h08, 1'b0},
    '{2'd0, 8'h24, 4'd8, 4'd0, 3'b010, 5'h08, 6'h10, 1'b1},
    '{2'd1, 8'h24, 4'd8, 4'd0, 3'b100, 5'h0F, 6'h20, 1'b0},
    '{2'd2, 8'h53, 4'd5, 4'd3, 3'b101, 5'h10, 6'h2E, 1'b1},
    '{2'd3, 8'h53, 4'd6, 4'd2, 3'b000, 5'h1F, 6'h00, 1'b0},
    '{2'd0, 8'hF0, 4'd8, 4'd0, 3'b000, 5'h04, 6'h0C, 1'b1},
    '{2'd1, 8'h24, 4'd2, 4'd4, 3'b111, 5'h00, 6'h3E, 1'b0}
  };

  vec_t v;
  int   c;

  initial begin
    repeat (50000) @(posedge clk);
    if (!done_flag) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // reset state
    #10;
    bus_addr = ra(0, 'h0C); #1 chk("R2 status in reset", rdata, 32'h0);
    chk("R8 irq in reset", 32'(irq), 32'h0);
    chk("R9 ctrl outs in reset", {27'h0, pm_en, chan_rst}, 32'h0);
    bus_addr = ra(1, 'h14); #1 chk("R6 thr reset", rdata, 32'h24);
    @(negedge clk); rst_n = 1'b1;

    // status/irq table
    for (int i = 0; i < 10; i++) begin
      v = VECS[i];
      c = int'(v.ch);
      tx_lvl[c*4 +: 4] = v.tx; rx_lvl[c*4 +: 4] = v.rx;
      wr(ra(c, 'h14), 32'(v.thr));
      wr(ra(c, 'h0C), 32'h3F);
      pulse(c, v.ev);
      rchk($sformatf("R3/R6 status vec %0d", i), ra(c, 'h0C), 32'(v.stat));
      wr(ra(c, 'h10), 32'(v.ien));
      #2 chk($sformatf("R8 irq vec %0d", i), 32'(irq), 32'(v.irq));
      wr(ra(c, 'h10), 32'h0);
      tx_lvl[c*4 +: 4] = 4'd8; rx_lvl[c*4 +: 4] = 4'd0;
      wr(ra(c, 'h14), 32'h24);
      wr(ra(c, 'h0C), 32'h3F);
    end

    // R1 bank layout and independence
    wr(ra(2, 'h00), 32'hA5A5_0F0F);
    rchk("R1 cfg ch2", ra(2, 'h00), 32'hA5A5_0F0F);
    rchk("R1 cfg ch1 untouched", ra(1, 'h00), 32'h0);
    chk("R1 cfg_o slice", cfg[64 +: 32], 32'hA5A5_0F0F);
    wr(ra(3, 'h04), 32'hFFFF_1234);
    rchk("R1 div width", ra(3, 'h04), 32'h1234);
    chk("R1 div_o slice", 32'(div[48 +: 16]), 32'h1234);
    wr(ra(0, 'h10), 32'hFFFF_FFFF);
    rchk("R1 ien width", ra(0, 'h10), 32'h1F);
    wr(ra(0, 'h10), 32'h0);
    wr(ra(1, 'h14), 32'hFFFF_FFFF);
    rchk("R1 thr width", ra(1, 'h14), 32'hFF);
    wr(ra(1, 'h14), 32'h24);
    wr(ra(1, 'h0C), 32'h3F);

    // R7 level word
    tx_lvl[12 +: 4] = 4'd5; rx_lvl[12 +: 4] = 4'd9;
    rchk("R7 wcnt ch3", ra(3, 'h18), 32'h59);
    tx_lvl[12 +: 4] = 4'd8; rx_lvl[12 +: 4] = 4'd0;

    // R2 live pending, unaffected by clear, excluded from irq (R8)
    busy[1] = 1'b1;
    rchk("R2 pending", ra(1, 'h0C), 32'h01);
    wr(ra(1, 'h0C), 32'hFFFF_FFFF);
    rchk("R4 pending not cleared", ra(1, 'h0C), 32'h01);
    wr(ra(1, 'h10), 32'h1F);
    #2 chk("R8 pending excluded", 32'(irq), 32'h0);
    wr(ra(1, 'h10), 32'h0);
    busy[1] = 1'b0;

    // R4 partial clear
    pulse(0, 3'b011);
    rchk("R4 before clear", ra(0, 'h0C), 32'h12);
    wr(ra(0, 'h0C), 32'h02);
    rchk("R4 clear bit1 only", ra(0, 'h0C), 32'h10);
    wr(ra(0, 'h0C), 32'h00);
    rchk("R4 zero write keeps", ra(0, 'h0C), 32'h10);
    wr(ra(0, 'h0C), 32'h10);

    // R5 set wins over clear
    @(negedge clk); bus_we = 1'b1; bus_addr = ra(0, 'h0C); bus_wdata = 32'h02; ev_done[0] = 1'b1;
    @(negedge clk); bus_we = 1'b0; ev_done = '0;
    rchk("R5 set wins", ra(0, 'h0C), 32'h02);
    wr(ra(0, 'h0C), 32'h3F);

    // R8 OR across channels
    pulse(0, 3'b001);
    pulse(3, 3'b100);
    wr(ra(0, 'h10), 32'h01);
    wr(ra(3, 'h10), 32'h10);
    #2 chk("R8 two sources", 32'(irq), 32'h1);
    wr(ra(0, 'h0C), 32'h02);
    #2 chk("R8 one source left", 32'(irq), 32'h1);
    wr(ra(3, 'h0C), 32'h20);
    #2 chk("R8 all cleared", 32'(irq), 32'h0);
    wr(ra(0, 'h10), 32'h0);
    wr(ra(3, 'h10), 32'h0);

    // R9 system control
    wr(9'h100, 32'hFFFF_FFFF);
    rchk("R9 sysctl mask", 9'h100, 32'h10F);
    chk("R9 outputs", {27'h0, pm_en, chan_rst}, 32'h1F);
    wr(9'h100, 32'h0);
    chk("R9 outputs cleared", {27'h0, pm_en, chan_rst}, 32'h0);

    // R10 command and channel reset
    @(negedge clk); bus_we = 1'b1; bus_addr = ra(2, 'h08); bus_wdata = 32'h001F_0013;
    #2 chk("R10 cmd_wr pulse", 32'(cmd_wr), 32'h4);
    @(negedge clk); bus_we = 1'b0;
    chk("R1 cmd_o slice", cmd[64 +: 32], 32'h001F_0013);
    wr(9'h100, 32'h4);
    rchk("R10 cmd idle in reset", ra(2, 'h08), 32'h0);
    busy[2] = 1'b1;
    pulse(2, 3'b111);
    rchk("R10 status held clear", ra(2, 'h0C), 32'h0);
    @(negedge clk); bus_we = 1'b1; bus_addr = ra(2, 'h08); bus_wdata = 32'h0000_0003;
    #2 chk("R10 cmd_wr suppressed", 32'(cmd_wr), 32'h0);
    @(negedge clk); bus_we = 1'b0;
    rchk("R10 cmd not stored", ra(2, 'h08), 32'h0);
    busy[2] = 1'b0;
    wr(9'h100, 32'h0);
    rchk("R10 after release", ra(2, 'h0C), 32'h0);

    // R11 data ports
    @(negedge clk); bus_we = 1'b1; bus_addr = ra(1, 'h1C); bus_wdata = 32'hDEAD_BEEF;
    #2 chk("R11 tx push", {28'h0, tx_push}, 32'h2);
    chk("R11 tx data", tx_data, 32'hDEAD_BEEF);
    @(negedge clk); bus_we = 1'b0;
    rx_data[96 +: 32] = 32'h1234_5678;
    @(negedge clk); bus_addr = ra(3, 'h20); bus_re = 1'b1;
    #2 chk("R11 rx data", rdata, 32'h1234_5678);
    chk("R11 rx pop", {28'h0, rx_pop}, 32'h8);
    @(negedge clk); bus_re = 1'b0;
    #2 chk("R11 no strobes idle", {24'h0, tx_push, rx_pop}, 32'h0);

    // R12 unmapped
    rchk("R12 idx 9", ra(0, 'h24), 32'h0);
    rchk("R12 above sysctl", 9'h104, 32'h0);
    rchk("R12 top", 9'h1FC, 32'h0);
    rchk("R12 unaligned", 9'h002, 32'h0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule